// File: doc/BRIEF.md
# Burst address sequencer for a pipelined on-chip bus master

This block sits on the master side of a pipelined on-chip bus. A requester supplies a start address, a burst code and a size code, then pulses `start`. The block produces the address phase of every beat in turn: the byte address, the two-bit transfer type and a flag that marks the final beat. It covers single transfers, fixed-length incrementing bursts, fixed-length wrapping bursts and incrementing bursts of open length.

The bus `ready` input stretches the current beat. While `ready` is low, every registered output holds. The requester can raise `busy_req` to put idle slots in the middle of a burst, and can end an open-length burst with `stop`. A request that would break the 1 KB burst limit is not issued. Instead it produces a one-cycle `err` pulse.

Top module: `burst_addr_gen`

## Requirements
- R1: During reset and in the cycle after it, `htrans` is 00 (IDLE), and `last` and `err` are 0.
- R2: `start` is sampled at a clock edge where `ready` is 1 and `htrans` is IDLE. In the next cycle `htrans` is 10 (NONSEQ) and `haddr` is the start address. Every later beat of the burst is 11 (SEQ). When no beat is pending, `htrans` returns to 00.
- R3: The burst code sets the length. 000 gives 1 beat, 001 gives an open length, 010 and 011 give 4 beats, 100 and 101 give 8 beats, and 110 and 111 give 16 beats. Codes 010, 100 and 110 wrap; all other codes increment.
- R4: The size code n sets the address step between beats to 2^n bytes, for n = 0..7. Incrementing bursts advance linearly. A word (n=2) 4-beat incrementing burst from 0x38 gives 0x38, 0x3C, 0x40, 0x44.
- R5: A wrapping burst stays inside the aligned window of (2^n × beats) bytes that holds the start address. A word 4-beat wrap from 0x38 gives 0x38, 0x3C, 0x30, 0x34.
- R6: `last` is 1 only on the final beat of a fixed-length burst. It is 1 only while `htrans` is NONSEQ or SEQ. Once that beat is taken with `ready` at 1, `htrans` is IDLE in the next cycle.
- R7: While `ready` is 0, `haddr`, `htrans` and the beat count hold, and `start` is ignored.
- R8: If `busy_req` is 1 when a non-final beat is taken, the next cycle shows 01 (BUSY) with the next address. BUSY repeats while `busy_req` stays 1. After that, the same address appears as SEQ. `busy_req` has no effect on a final beat.
- R9: In an open-length burst, `last` is 1 on any beat shown while `stop` is 1. It is also 1 on a beat whose following address would lie in another 1 KB block.
- R10: In the following cases, `err` is 1 for the next cycle and no beat is issued: a fixed incrementing or single request whose bytes would cross a 1 KB boundary, or a wrapping request whose window is larger than 1 KB.
- R11: A `start` pulse during an active burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request pulse |
| start_addr | input | AW | First byte address |
| burst_code | input | 3 | Burst type and length code |
| size_code | input | 3 | Transfer size, 2^n bytes |
| busy_req | input | 1 | Insert an idle slot after the current beat |
| stop | input | 1 | End an open-length burst on the current beat |
| ready | input | 1 | Bus ready; low stretches the current beat |
| haddr | output | AW | Beat address |
| htrans | output | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| last | output | 1 | Final beat of the burst |
| err | output | 1 | Rejected request, one cycle |

## Verification
Results appear on the following timetable:
- The first beat appears one clock after the edge that samples `start`.
- Each later beat appears one clock after the edge that takes the previous beat.
- A rejection shows on `err` one clock after the sampling edge and is gone one clock later.
- `last` in an open-length burst follows `stop` in the same cycle.

The bench drives every input on the falling edge and steps exactly one rising edge before each sample. It then reads the outputs on the next falling edge, so every expected value is checked in the cycle it is due. During stalls it checks every stretched cycle, and after every final beat it checks the IDLE cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam logic [2:0] BC_SINGLE = 3'b000;
  localparam logic [2:0] BC_OPEN   = 3'b001;
endpackage

// File: rtl/bag_rst_sync.sv
module bag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bag_decode.sv
module bag_decode #(
  parameter int AW      = 32,
  parameter int KB_BITS = 10
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    code_i,
  input  logic [2:0]    size_i,
  output logic [3:0]    cnt_o,
  output logic [2:0]    blog_o,
  output logic          wrap_o,
  output logic          open_o,
  output logic          reject_o
);
  import bag_pkg::*;

  localparam int TW = KB_BITS + 3;

  logic [3:0]    tot_log;
  logic [TW-1:0] span;
  logic [TW-1:0] end_off;

  always_comb begin
    unique case (code_i)
      3'b010, 3'b011: blog_o = 3'd2;
      3'b100, 3'b101: blog_o = 3'd3;
      3'b110, 3'b111: blog_o = 3'd4;
      default:        blog_o = 3'd0;
    endcase
  end

  assign open_o  = (code_i == BC_OPEN);
  assign wrap_o  = (code_i != BC_SINGLE) && !code_i[0];
  assign cnt_o   = 4'((5'd1 << blog_o) - 5'd1);
  assign tot_log = {1'b0, size_i} + {1'b0, blog_o};
  assign span    = {{(TW-1){1'b0}}, 1'b1} << tot_log;
  assign end_off = {3'b000, addr_i[KB_BITS-1:0]} + span;

  always_comb begin
    if (open_o)      reject_o = 1'b0;
    else if (wrap_o) reject_o = (int'(tot_log) > KB_BITS);
    else             reject_o = (end_off > ({{(TW-1){1'b0}}, 1'b1} << KB_BITS));
  end
endmodule

// File: rtl/bag_next_addr.sv
module bag_next_addr #(
  parameter int AW      = 32,
  parameter int KB_BITS = 10
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  input  logic [2:0]    blog_i,
  input  logic          wrap_i,
  output logic [AW-1:0] next_o,
  output logic          kb_end_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] step;
  logic [AW-1:0] inc;
  logic [AW-1:0] mask;
  logic [3:0]    win_log;

  assign step    = ONE << size_i;
  assign inc     = addr_i + step;
  assign win_log = {1'b0, size_i} + {1'b0, blog_i};
  assign mask    = (ONE << win_log) - ONE;

  generate
    if (AW > KB_BITS) begin : g_kb
      assign kb_end_o = (inc[AW-1:KB_BITS] != addr_i[AW-1:KB_BITS]);
    end else begin : g_nokb
      assign kb_end_o = 1'b0;
    end
  endgenerate

  assign next_o = wrap_i ? ((addr_i & ~mask) | (inc & mask)) : inc;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW      = 32,
  parameter int KB_BITS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [2:0]    burst_code,
  input  logic [2:0]    size_code,
  input  logic          busy_req,
  input  logic          stop,
  input  logic          ready,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          last,
  output logic          err
);
  import bag_pkg::*;

  logic          rst_n_s;
  trans_e        trans_q, trans_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [2:0]    size_q, size_d;
  logic [2:0]    blog_q, blog_d;
  logic          wrap_q, wrap_d;
  logic          open_q, open_d;
  logic          err_q, err_d;

  logic [3:0]    dec_cnt;
  logic [2:0]    dec_blog;
  logic          dec_wrap, dec_open, dec_reject;
  logic [AW-1:0] nxt_addr;
  logic          kb_end;
  logic          active, is_last, step_en;

  bag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  bag_decode #(.AW(AW), .KB_BITS(KB_BITS)) u_dec (
    .addr_i(start_addr), .code_i(burst_code), .size_i(size_code),
    .cnt_o(dec_cnt), .blog_o(dec_blog), .wrap_o(dec_wrap),
    .open_o(dec_open), .reject_o(dec_reject)
  );

  bag_next_addr #(.AW(AW), .KB_BITS(KB_BITS)) u_nxt (
    .addr_i(addr_q), .size_i(size_q), .blog_i(blog_q), .wrap_i(wrap_q),
    .next_o(nxt_addr), .kb_end_o(kb_end)
  );

  assign active  = (trans_q == TR_NSEQ) || (trans_q == TR_SEQ);
  assign is_last = active && (open_q ? (stop || kb_end) : (cnt_q == 4'd0));
  assign step_en = ready;

  always_comb begin
    trans_d = trans_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    size_d  = size_q;
    blog_d  = blog_q;
    wrap_d  = wrap_q;
    open_d  = open_q;
    err_d   = 1'b0;
    if (ready) begin
      unique case (trans_q)
        TR_IDLE: begin
          if (start) begin
            if (dec_reject) begin
              err_d = 1'b1;
            end else begin
              trans_d = TR_NSEQ;
              addr_d  = start_addr;
              cnt_d   = dec_cnt;
              size_d  = size_code;
              blog_d  = dec_blog;
              wrap_d  = dec_wrap;
              open_d  = dec_open;
            end
          end
        end
        TR_BUSY: trans_d = busy_req ? TR_BUSY : TR_SEQ;
        default: begin
          if (is_last) begin
            trans_d = TR_IDLE;
          end else begin
            addr_d  = nxt_addr;
            cnt_d   = open_q ? cnt_q : cnt_q - 4'd1;
            trans_d = busy_req ? TR_BUSY : TR_SEQ;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      trans_q <= TR_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      blog_q  <= '0;
      wrap_q  <= 1'b0;
      open_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_d;
      if (step_en) begin
        trans_q <= trans_d;
        addr_q  <= addr_d;
        cnt_q   <= cnt_d;
        size_q  <= size_d;
        blog_q  <= blog_d;
        wrap_q  <= wrap_d;
        open_q  <= open_d;
      end
    end
  end

  assign haddr  = addr_q;
  assign htrans = trans_q;
  assign last   = is_last;
  assign err    = err_q;
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int AW      = 32,
  parameter int KB_BITS = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_req,
  input logic          ready,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic          last,
  input logic          err
);
  p_first_nonseq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b00 |=> (htrans == 2'b00 || htrans == 2'b10));

  p_last_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> htrans[1]);

  p_idle_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && ready) |=> htrans == 2'b00);

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00 && !ready) |=> ($stable(haddr) && $stable(htrans)));

  p_busy_to_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b01 && ready && !busy_req) |=> (htrans == 2'b11 && $stable(haddr)));

  p_no_kb_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && ready && !last) |=> haddr[AW-1:KB_BITS] == $past(haddr[AW-1:KB_BITS]));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (htrans == 2'b00 && !last));
endmodule

bind burst_addr_gen bag_checker #(.AW(AW), .KB_BITS(KB_BITS)) u_bag_checker (
  .clk(clk), .rst_n(rst_n), .busy_req(busy_req), .ready(ready),
  .haddr(haddr), .htrans(htrans), .last(last), .err(err)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [2:0]    burst_code = '0;
  logic [2:0]    size_code = '0;
  logic          busy_req = 1'b0;
  logic          stop = 1'b0;
  logic          ready = 1'b1;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic          last;
  logic          err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .burst_code(burst_code), .size_code(size_code), .busy_req(busy_req),
    .stop(stop), .ready(ready), .haddr(haddr), .htrans(htrans),
    .last(last), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic see(input logic [31:0] a, input logic [1:0] t, input logic l, input string req);
    chk(haddr == a, req, "haddr", haddr, a);
    chk(htrans == t, req, "htrans", {30'b0, htrans}, {30'b0, t});
    chk(last == l, req, "last", {31'b0, last}, {31'b0, l});
  endtask

  task automatic see_idle(input string req);
    chk(htrans == 2'b00, req, "htrans idle", {30'b0, htrans}, 32'h0);
    chk(last == 1'b0, req, "last idle", {31'b0, last}, 32'h0);
  endtask

  task automatic issue(input logic [31:0] a, input logic [2:0] code, input logic [2:0] sz);
    start = 1'b1; start_addr = a; burst_code = code; size_code = sz;
    tick();
    start = 1'b0;
  endtask

  // fixed-length burst; poke_at >= 0 pulses a foreign start on that beat (R11)
  task automatic run_fixed(input logic [31:0] a, input logic [2:0] code, input logic [2:0] sz,
                           input int nb, input bit wrp, input int poke_at, input string req);
    logic [31:0] step, win, base, exp;
    step = 32'd1 << sz;
    win  = step * nb;
    base = a & ~(win - 1);
    issue(a, code, sz);
    for (int i = 0; i < nb; i++) begin
      exp = wrp ? base + (((a - base) + i * step) % win) : a + i * step;
      see(exp, (i == 0) ? 2'b10 : 2'b11, (i == nb - 1), req);
      if (i == poke_at) begin
        start = 1'b1; start_addr = 32'h0000_0800; burst_code = 3'b000;
      end
      tick();
      start = 1'b0;
    end
    see_idle(req);
  endtask

  task automatic t_reset();
    chk(htrans == 2'b00, "R1", "htrans", {30'b0, htrans}, 32'h0);
    chk(last == 1'b0, "R1", "last", {31'b0, last}, 32'h0);
    chk(err == 1'b0, "R1", "err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_wrap4();   // R5 R2 R6
    run_fixed(32'h38, 3'b010, 3'd2, 4, 1'b1, -1, "R5");
  endtask

  task automatic t_incr4();   // R4 R3
    run_fixed(32'h38, 3'b011, 3'd2, 4, 1'b0, -1, "R4");
  endtask

  task automatic t_wrap8_half();   // R5 R3
    run_fixed(32'h1A, 3'b100, 3'd1, 8, 1'b1, -1, "R5");
  endtask

  task automatic t_incr16_edge();  // R10 boundary: ends exactly at 1 KB, allowed
    run_fixed(32'h3C0, 3'b111, 3'd2, 16, 1'b0, -1, "R10");
    chk(err == 1'b0, "R10", "err on exact fit", {31'b0, err}, 32'h0);
  endtask

  task automatic t_single_busy();  // R8: busy_req ignored on a final beat; R3 single
    busy_req = 1'b1;
    run_fixed(32'h101, 3'b000, 3'd0, 1, 1'b0, -1, "R8");
    busy_req = 1'b0;
  endtask

  task automatic t_start_ignored();  // R11
    run_fixed(32'h200, 3'b101, 3'd3, 8, 1'b0, 2, "R11");
  endtask

  task automatic t_busy_open();  // R8 R9
    issue(32'h20, 3'b001, 3'd2);
    see(32'h20, 2'b10, 1'b0, "R8");
    busy_req = 1'b1;
    tick();
    see(32'h24, 2'b01, 1'b0, "R8");
    tick();
    see(32'h24, 2'b01, 1'b0, "R8");
    busy_req = 1'b0;
    tick();
    see(32'h24, 2'b11, 1'b0, "R8");
    tick();
    see(32'h28, 2'b11, 1'b0, "R9");
    tick();
    stop = 1'b1;
    #0.1;
    see(32'h2C, 2'b11, 1'b1, "R9");
    tick();
    stop = 1'b0;
    see_idle("R9");
  endtask

  task automatic t_open_kb();  // R9 forced end at the 1 KB block edge
    issue(32'h3F8, 3'b001, 3'd2);
    see(32'h3F8, 2'b10, 1'b0, "R9");
    tick();
    see(32'h3FC, 2'b11, 1'b1, "R9");
    tick();
    see_idle("R9");
  endtask

  task automatic t_stall();  // R7
    issue(32'h100, 3'b011, 3'd2);
    see(32'h100, 2'b10, 1'b0, "R7");
    tick();
    see(32'h104, 2'b11, 1'b0, "R7");
    ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      see(32'h104, 2'b11, 1'b0, "R7");
    end
    ready = 1'b1;
    tick();
    see(32'h108, 2'b11, 1'b0, "R7");
    tick();
    see(32'h10C, 2'b11, 1'b1, "R7");
    tick();
    see_idle("R7");
    ready = 1'b0;
    issue(32'h40, 3'b000, 3'd2);
    see_idle("R7");
    ready = 1'b1;
    tick();
    see_idle("R7");
  endtask

  task automatic t_reject();  // R10
    issue(32'h3F0, 3'b111, 3'd2);
    chk(err == 1'b1, "R10", "err incr cross", {31'b0, err}, 32'h1);
    see_idle("R10");
    tick();
    chk(err == 1'b0, "R10", "err cleared", {31'b0, err}, 32'h0);
    see_idle("R10");
    issue(32'h0, 3'b110, 3'd7);
    chk(err == 1'b1, "R10", "err wide wrap", {31'b0, err}, 32'h1);
    tick();
    see_idle("R10");
    run_fixed(32'h3F8, 3'b010, 3'd2, 4, 1'b1, -1, "R10");
    chk(err == 1'b0, "R10", "err on wrap in block", {31'b0, err}, 32'h0);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    tick();
    tick();
    t_reset();
    t_wrap4();
    t_incr4();
    t_wrap8_half();
    t_incr16_edge();
    t_single_busy();
    t_start_ignored();
    t_busy_open();
    t_open_kb();
    t_stall();
    t_reject();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule